// File: doc/BRIEF.md
# Programmable CRTC display timing generator

This block produces the raster timing for a display controller. A horizontal
pixel counter and a vertical line counter run on a pixel-clock enable. From
them the block derives a display-enable, a horizontal sync pulse, a vertical
sync pulse and a line-start address that steps by a programmable pitch on
every active line. All geometry comes from packed timing words. Horizontal
totals and active widths use 8-pixel character units stored minus one.
Vertical totals, active heights and sync starts are stored minus one. Each
sync has its own width field and its own polarity bit.

Software writes the timing words through a simple write port. The block keeps
them in shadow copies and moves them to the working set only at the start of a
frame. While the global enable is clear the working set follows the shadows,
so a mode can be loaded before scan-out begins. Three disable bits force
display-enable, hsync and vsync to their inactive levels for blanking. These
bits act at once.

Top module: `crtc_timing`

## Requirements
- R1: After reset, and whenever the enable bit (control word at address 0, bit 0) is clear, xpos, ypos and line_addr are 0, de is 0, and each sync output sits at its inactive level (equal to its polarity bit; 0 after reset).
- R2: With enable set, xpos advances by one on each cycle with pix_en high. It wraps to 0 after (HT+1)*8-1, where HT is bits [9:0] of the horizontal word (address 1). On that wrap ypos advances. ypos wraps to 0 after VT, where VT is bits [15:0] of the vertical word (address 3).
- R3: On a cycle with pix_en low, xpos, ypos and line_addr hold their values.
- R4: de is high exactly when xpos < (HA+1)*8 and ypos <= VA, where HA is bits [24:16] of address 1 and VA is bits [31:16] of address 3.
- R5: hsync is asserted for xpos in [HS, HS+8*HW). HS is bits [12:0] and HW is bits [21:16] of the horizontal sync word (address 2).
- R6: vsync is asserted for ypos in [VS+1, VS+1+VW). VS is bits [11:0] and VW is bits [20:16] of the vertical sync word (address 4).
- R7: A sync width field of zero gives the same pulse as a width of one.
- R8: Bit 23 of each sync word is its polarity. When it is set, the pulse is active-low and idles high. When it is clear, the pulse is active-high and idles low.
- R9: Control bit 1 forces de low, bit 2 forces hsync inactive, and bit 3 forces vsync inactive. Each takes effect on the cycle after the write.
- R10: line_addr returns to 0 at each frame start. It advances by the pitch (bits [15:0] of address 5; the upper half is ignored) when an active line (ypos <= VA) ends.
- R11: A timing word written while enable is set takes effect only at the next frame wrap. While enable is clear, it takes effect one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 control, 1 h total/active, 2 h sync, 3 v total/active, 4 v sync, 5 pitch |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| xpos | output | 13 | Current pixel within the line |
| ypos | output | 16 | Current line within the frame |
| line_addr | output | AW | Start address of the current line, in 8-pixel units |

## Verification
The bench keeps an arithmetic raster model and compares every output on every cycle. It runs a small base mode, then a mid-frame mode change, which shows whether new words wait for the frame wrap. It runs both polarities and zero sync widths, which separate inverted pulses from width-one pulses. Each blanking disable is set on its own, which shows that each acts only on its own output. A pseudo-random pix_en pattern catches counters that run without the enable. A sweep of the sync start across every pixel of the line, with varying widths, exposes off-by-one edges in the pulse window.

// File: rtl/crtc_timing.sv
module crtc_timing #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [12:0]   xpos,
  output logic [15:0]   ypos,
  output logic [AW-1:0] line_addr
);
  localparam int CW = 19 + 20 + 32 + 18 + 16;

  logic [3:0]    ctl;
  logic [CW-1:0] shd, act;

  logic [9:0]  a_htot;
  logic [8:0]  a_hact;
  logic        a_hpol;
  logic [5:0]  a_hw;
  logic [12:0] a_hst;
  logic [15:0] a_vact, a_vtot;
  logic        a_vpol;
  logic [4:0]  a_vw;
  logic [11:0] a_vst;
  logic [15:0] a_pitch;

  assign {a_hact, a_htot, a_hpol, a_hw, a_hst, a_vact, a_vtot,
          a_vpol, a_vw, a_vst, a_pitch} = act;

  wire        run      = ctl[0];
  wire [12:0] x_last   = {a_htot, 3'b111};
  wire        line_end = xpos == x_last;
  wire        frm_end  = line_end && ypos == a_vtot;

  wire [5:0]  hw_eff = (a_hw == 6'd0) ? 6'd1 : a_hw;
  wire [13:0] hs_end = {1'b0, a_hst} + {5'b0, hw_eff, 3'b000};
  wire        h_in   = xpos >= a_hst && {1'b0, xpos} < hs_end;

  wire [4:0]  vw_eff = (a_vw == 5'd0) ? 5'd1 : a_vw;
  wire [12:0] vs_st  = {1'b0, a_vst} + 13'd1;
  wire [16:0] vs_end = {4'b0, vs_st} + {12'b0, vw_eff};
  wire        v_in   = ypos >= {3'b0, vs_st} && {1'b0, ypos} < vs_end;

  wire de_h = xpos[12:3] <= {1'b0, a_hact};
  wire de_v = ypos <= a_vact;

  assign de    = run & ~ctl[1] & de_h & de_v;
  assign hsync = a_hpol ^ (run & ~ctl[2] & h_in);
  assign vsync = a_vpol ^ (run & ~ctl[3] & v_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
      shd <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: ctl <= wr_data[3:0];
        3'd1: shd[CW-1 -: 19] <= {wr_data[24:16], wr_data[9:0]};
        3'd2: shd[CW-20 -: 20] <= {wr_data[23], wr_data[21:16], wr_data[12:0]};
        3'd3: shd[CW-40 -: 32] <= wr_data;
        3'd4: shd[33:16] <= {wr_data[23], wr_data[20:16], wr_data[11:0]};
        3'd5: shd[15:0] <= wr_data[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act       <= '0;
      xpos      <= '0;
      ypos      <= '0;
      line_addr <= '0;
    end else if (!run) begin
      act       <= shd;
      xpos      <= '0;
      ypos      <= '0;
      line_addr <= '0;
    end else if (pix_en) begin
      if (!line_end) begin
        xpos <= xpos + 13'd1;
      end else begin
        xpos <= '0;
        if (frm_end) begin
          ypos      <= '0;
          line_addr <= '0;
          act       <= shd;
        end else begin
          ypos <= ypos + 16'd1;
          if (de_v) line_addr <= line_addr + AW'(a_pitch);
        end
      end
    end
  end
endmodule

module crtc_timing_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          run,
  input logic          no_de,
  input logic          line_end,
  input logic          de,
  input logic [12:0]   xpos,
  input logic [15:0]   ypos,
  input logic [AW-1:0] line_addr
);
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (xpos == 13'd0 && ypos == 16'd0 && line_addr == '0));

  assert_x_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pix_en && !line_end) |=> (!$past(run) || xpos == $past(xpos) + 13'd1 || !run || xpos == 13'd0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pix_en) |=> ($stable(xpos) && $stable(ypos) && $stable(line_addr)));

  assert_de_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (no_de || !run) |-> !de);

  assert_addr_midline_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !line_end) |=> $stable(line_addr));
endmodule

bind crtc_timing crtc_timing_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .run(ctl[0]), .no_de(ctl[1]),
  .line_end(line_end), .de(de), .xpos(xpos), .ypos(ypos), .line_addr(line_addr)
);

// File: tb/tb_crtc_timing.sv
`timescale 1ns/1ps
module tb_crtc_timing;
  localparam int AW = 24;

  logic clk = 0, rst_n = 0, pix_en = 1, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic hsync, vsync, de;
  logic [12:0] xpos;
  logic [15:0] ypos;
  logic [AW-1:0] line_addr;

  crtc_timing #(.AW(AW)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit chk_on = 0, pe_rand = 0, done = 0;
  string phase = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // model state
  int mx, my, mla;
  logic [31:0] mctl, sh[1:5], ac[1:5];

  task automatic chk(string tag, int act_v, int exp_v, string what);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s (%s) phase %s: actual %0d expected %0d at cycle %0d",
               tag, what, phase, act_v, exp_v, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mx = 0; my = 0; mla = 0; mctl = 0;
      for (int i = 1; i <= 5; i++) begin sh[i] = 0; ac[i] = 0; end
    end else begin
      if (!mctl[0]) begin
        mx = 0; my = 0; mla = 0;
        for (int i = 1; i <= 5; i++) ac[i] = sh[i];
      end else if (pix_en) begin
        if (mx == (int'(ac[1][9:0]) + 1) * 8 - 1) begin
          mx = 0;
          if (my == int'(ac[3][15:0])) begin
            my = 0; mla = 0;
            for (int i = 1; i <= 5; i++) ac[i] = sh[i];
          end else begin
            if (my <= int'(ac[3][31:16])) mla = (mla + int'(ac[5][15:0])) % (1 << AW);
            my++;
          end
        end else mx++;
      end
      if (wr_en) begin
        if (wr_addr == 0) mctl = wr_data;
        else if (wr_addr <= 5) sh[wr_addr] = wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (pe_rand) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pix_en <= lfsr[0] | lfsr[3];
    end else pix_en <= 1'b1;
  end

  always @(negedge clk) begin
    if (chk_on) begin
      int hw, vw, vs, e_de, e_hs, e_vs;
      bit en;
      en = mctl[0];
      hw = (ac[2][21:16] == 0) ? 1 : int'(ac[2][21:16]);
      vw = (ac[4][20:16] == 0) ? 1 : int'(ac[4][20:16]);
      vs = int'(ac[4][11:0]) + 1;
      e_de = (en && !mctl[1] && mx < (int'(ac[1][24:16]) + 1) * 8 &&
              my <= int'(ac[3][31:16])) ? 1 : 0;
      e_hs = int'(ac[2][23]) ^ ((en && !mctl[2] && mx >= int'(ac[2][12:0]) &&
              mx < int'(ac[2][12:0]) + 8 * hw) ? 1 : 0);
      e_vs = int'(ac[4][23]) ^ ((en && !mctl[3] && my >= vs && my < vs + vw) ? 1 : 0);
      chk("R2", int'(xpos), mx, "xpos");
      chk("R2", int'(ypos), my, "ypos");
      chk("R4", int'(de), e_de, "de");
      chk("R5", int'(hsync), e_hs, "hsync");
      chk("R6", int'(vsync), e_vs, "vsync");
      chk("R10", int'(line_addr), mla, "line_addr");
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en <= 1; wr_addr <= a; wr_data <= d;
    @(negedge clk);
    wr_en <= 0;
  endtask

  task automatic run_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run_cyc(4);
    #1;
    // R1: reset state at the ports
    chk("R1", int'(xpos), 0, "xpos");
    chk("R1", int'(ypos), 0, "ypos");
    chk("R1", int'(de), 0, "de");
    chk("R1", int'(hsync), 0, "hsync");
    chk("R1", int'(vsync), 0, "vsync");
    chk("R1", int'(line_addr), 0, "line_addr");
    rst_n = 1;
    chk_on = 1;

    // R2: base mode, 32 px line, 16 active, 6 lines, 4 active
    phase = "R2";
    wr(1, 32'h0001_0003);
    wr(2, 32'h0001_0014);
    wr(3, 32'h0003_0005);
    wr(4, 32'h0001_0003);
    wr(5, 32'h0005_0005);
    wr(0, 32'h1);
    run_cyc(450);

    // R11: mid-frame rewrite waits for the frame wrap
    phase = "R11";
    run_cyc(37);
    wr(1, 32'h0002_0004);
    wr(3, 32'h0004_0006);
    run_cyc(600);

    // R8: both polarities active-low
    phase = "R8";
    wr(2, 32'h0081_0010);
    wr(4, 32'h0082_0002);
    run_cyc(700);

    // R7: zero widths behave as one
    phase = "R7";
    wr(2, 32'h0000_0008);
    wr(4, 32'h0080_0001);
    run_cyc(700);

    // R9: each blanking disable alone
    phase = "R9";
    wr(0, 32'h3); run_cyc(300);
    wr(0, 32'h5); run_cyc(300);
    wr(0, 32'h9); run_cyc(300);
    wr(0, 32'h1); run_cyc(100);

    // R3: pseudo-random pixel enable
    phase = "R3";
    pe_rand = 1;
    run_cyc(2000);
    pe_rand = 0;

    // R1: enable cleared holds everything at zero, words load at once
    phase = "R1";
    wr(0, 32'h0);
    wr(3, 32'h0003_0003);
    wr(5, 32'hFFFF_0007);
    run_cyc(50);

    // R10: every line active, pitch from low half only
    phase = "R10";
    wr(0, 32'h1);
    run_cyc(800);

    // R5: sweep sync start across the line with varying widths
    phase = "R5";
    for (int s = 0; s < 40; s++) begin
      wr(2, (32'(s % 3) << 16) | 32'(s) | ((s % 2) ? 32'h0080_0000 : 32'h0));
      wr(4, (32'(s % 4) << 16) | 32'(s % 3));
      run_cyc(330);
    end

    chk_on = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule